// File: doc/BRIEF.md
# Cipher Feedback Chaining Controller

This block is the sequencer and data path that wrap a 128-bit block-cipher encrypt engine so that a stream of plaintext blocks can be encrypted in cipher feedback fashion, with two level-sensitive DMA request lines doing all per-block data movement. It holds a 128-bit chaining register. A 16-bit write port XORs a word into that register. A 16-bit read port presents one word of it at a time. A word pointer walks the eight words of a block.

Software clears the register with the soft reset input and writes the initialization vector through the XOR port. Because the register starts at zero, the vector lands in it unchanged. Software then loads a block count and pulses the start input. Each time the engine finishes, its result replaces the register. The plaintext request stays high until eight words have been XORed in, which turns the register into ciphertext. The ciphertext request then stays high until eight words have been read out. The eighth read either launches the next encryption on the ciphertext still held in the register, or ends the run with a one-cycle done pulse.

The controller phases are named IDLE, CIPHER (engine running), FILL (plaintext request) and DRAIN (ciphertext request). It moves through them as follows:
- IDLE to CIPHER when start is seen with a nonzero count.
- CIPHER to FILL on engine done.
- FILL to DRAIN on the eighth write.
- DRAIN to CIPHER on the eighth read while blocks remain.
- DRAIN to IDLE on the eighth read of the last block.
- Any phase to IDLE on soft reset.

Top module: `cfb_chain_ctrl`

## Requirements
- R1: A soft reset (or rst_n low) clears the 128-bit register to zero, returns the word pointer to word 0 and the controller to IDLE, and drops both request lines.
- R2: In IDLE each write XORs wr_data into the register word selected by the pointer and advances the pointer. Word k occupies bits [16k+15:16k], for k from 0 to 7. Such writes never start the engine.
- R3: A start pulse in IDLE with a nonzero block count raises eng_start for exactly one cycle, beginning the next cycle. While eng_start is high, eng_state_out carries the register. A start pulse with a zero count is ignored.
- R4: When eng_done arrives in CIPHER, the register takes eng_result, the pointer returns to word 0, and req_in is high from the next cycle.
- R5: req_in stays high until eight words have been XOR-written, word 0 first. The cycle after the eighth write, req_in is low and req_out is high. The two requests are never high together.
- R6: While req_out is high, rd_data shows register word 0 first and then each following word. Each rd_en advances the pointer, and eight reads end the phase.
- R7: After the eighth read, the block count drops by one. If blocks remain, eng_start pulses the next cycle and the engine input is the ciphertext just read.
- R8: After the eighth read of the last block, done pulses for one cycle, the controller is IDLE and eng_start stays low.
- R9: Writes outside IDLE and FILL leave the register unchanged. Reads outside DRAIN do not move the pointer.
- R10: Block count writes are taken only in IDLE. A count write during a run does not change how many blocks that run processes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of register, pointer, count and phase |
| wr_en | input | 1 | XOR-write strobe |
| wr_data | input | 16 | Word XORed into the register |
| rd_en | input | 1 | Output-word read strobe |
| rd_data | output | 16 | Register word at the pointer |
| cnt_we | input | 1 | Block count write strobe |
| cnt_wdata | input | 16 | Block count value |
| go | input | 1 | Start command |
| req_in | output | 1 | Level request for plaintext writes |
| req_out | output | 1 | Level request for ciphertext reads |
| done | output | 1 | One-cycle pulse at the end of the run |
| eng_start | output | 1 | Engine start pulse |
| eng_state_out | output | 128 | Register contents toward the engine |
| eng_done | input | 1 | Engine finished |
| eng_result | input | 128 | Engine output block |

## Verification
The assertions check the following on every cycle:
- eng_start and done are single-cycle pulses, and done never comes with a start.
- The two request lines are exclusive.
- A soft reset empties the register and drops the requests.
- An engine completion in CIPHER loads the result and raises req_in.
- The register holds still in CIPHER and DRAIN, apart from engine loads.

Only the bench's scenarios can show the rest:
- The ciphertext values themselves, which depend on the XOR arithmetic across chained blocks.
- That the eighth read of a block starts the next encryption on that ciphertext.
- That a zero-count start, stray reads and writes, and count writes during a run have no effect.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CIPHER = 2'd1,
        PH_FILL   = 2'd2,
        PH_DRAIN  = 2'd3
    } cfb_phase_e;
endpackage

// File: rtl/cfb_state_reg.sv
module cfb_state_reg #(
    parameter int WORD_W = 16,
    parameter int WORDS  = 8,
    localparam int BLK_W = WORD_W * WORDS,
    localparam int PTR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              xor_en,
    input  logic [WORD_W-1:0] xor_word,
    input  logic [PTR_W-1:0]  word_sel,
    input  logic              load_en,
    input  logic [BLK_W-1:0]  load_val,
    output logic [BLK_W-1:0]  state,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] lane [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane[g] <= '0;
            end else if (clr) begin
                lane[g] <= '0;
            end else if (load_en) begin
                lane[g] <= load_val[g*WORD_W +: WORD_W];
            end else if (xor_en && (word_sel == PTR_W'(g))) begin
                lane[g] <= lane[g] ^ xor_word;
            end
        end
        assign state[g*WORD_W +: WORD_W] = lane[g];
    end

    assign rd_word = lane[word_sel];
endmodule

// File: rtl/cfb_word_ptr.sv
module cfb_word_ptr #(
    parameter int WORDS = 8,
    localparam int PTR_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr,
    output logic             at_last
);
    assign at_last = (ptr == PTR_W'(WORDS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= at_last ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/cfb_blk_counter.sv
module cfb_blk_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero,
    output logic             is_one
);
    logic [CNT_W-1:0] cnt;

    assign is_zero = (cnt == '0);
    assign is_one  = (cnt == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && !is_zero) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/cfb_fsm.sv
module cfb_fsm
    import cfb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       go,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       eng_done,
    input  logic       ptr_last,
    input  logic       cnt_zero,
    input  logic       cnt_one,
    output cfb_phase_e phase,
    output logic       xor_en,
    output logic       load_en,
    output logic       ptr_clr,
    output logic       ptr_adv,
    output logic       cnt_load,
    output logic       cnt_dec,
    output logic       req_in,
    output logic       req_out,
    output logic       eng_start,
    output logic       done
);
    cfb_phase_e phase_nx;
    logic       start_nx;
    logic       done_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            eng_start <= 1'b0;
            done      <= 1'b0;
        end else if (soft_rst) begin
            phase     <= PH_IDLE;
            eng_start <= 1'b0;
            done      <= 1'b0;
        end else begin
            phase     <= phase_nx;
            eng_start <= start_nx;
            done      <= done_nx;
        end
    end

    always_comb begin
        phase_nx = phase;
        start_nx = 1'b0;
        done_nx  = 1'b0;
        xor_en   = 1'b0;
        load_en  = 1'b0;
        ptr_clr  = 1'b0;
        ptr_adv  = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        req_in   = 1'b0;
        req_out  = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                xor_en   = wr_en;
                ptr_adv  = wr_en;
                cnt_load = 1'b1;
                if (go && !cnt_zero) begin
                    phase_nx = PH_CIPHER;
                    start_nx = 1'b1;
                    ptr_clr  = 1'b1;
                end
            end
            PH_CIPHER: begin
                if (eng_done) begin
                    load_en  = 1'b1;
                    ptr_clr  = 1'b1;
                    phase_nx = PH_FILL;
                end
            end
            PH_FILL: begin
                req_in  = 1'b1;
                xor_en  = wr_en;
                ptr_adv = wr_en;
                if (wr_en && ptr_last) begin
                    phase_nx = PH_DRAIN;
                end
            end
            PH_DRAIN: begin
                req_out = 1'b1;
                ptr_adv = rd_en;
                if (rd_en && ptr_last) begin
                    cnt_dec = 1'b1;
                    if (cnt_one || cnt_zero) begin
                        phase_nx = PH_IDLE;
                        done_nx  = 1'b1;
                    end else begin
                        phase_nx = PH_CIPHER;
                        start_nx = 1'b1;
                    end
                end
            end
            default: phase_nx = PH_IDLE;
        endcase
    end
endmodule

// File: rtl/cfb_chain_ctrl.sv
module cfb_chain_ctrl #(
    parameter int WORD_W = 16,
    parameter int WORDS  = 8,
    parameter int CNT_W  = 16,
    localparam int BLK_W = WORD_W * WORDS,
    localparam int PTR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              go,
    output logic              req_in,
    output logic              req_out,
    output logic              done,
    output logic              eng_start,
    output logic [BLK_W-1:0]  eng_state_out,
    input  logic              eng_done,
    input  logic [BLK_W-1:0]  eng_result
);
    import cfb_pkg::*;

    cfb_phase_e       phase;
    logic             xor_en, load_en, ptr_clr, ptr_adv;
    logic             cnt_load, cnt_dec, cnt_zero, cnt_one;
    logic [PTR_W-1:0] ptr;
    logic             ptr_last;

    cfb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .go        (go),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .eng_done  (eng_done),
        .ptr_last  (ptr_last),
        .cnt_zero  (cnt_zero),
        .cnt_one   (cnt_one),
        .phase     (phase),
        .xor_en    (xor_en),
        .load_en   (load_en),
        .ptr_clr   (ptr_clr),
        .ptr_adv   (ptr_adv),
        .cnt_load  (cnt_load),
        .cnt_dec   (cnt_dec),
        .req_in    (req_in),
        .req_out   (req_out),
        .eng_start (eng_start),
        .done      (done)
    );

    cfb_state_reg #(.WORD_W(WORD_W), .WORDS(WORDS)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .xor_en   (xor_en),
        .xor_word (wr_data),
        .word_sel (ptr),
        .load_en  (load_en),
        .load_val (eng_result),
        .state    (eng_state_out),
        .rd_word  (rd_data)
    );

    cfb_word_ptr #(.WORDS(WORDS)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_rst || ptr_clr),
        .adv     (ptr_adv),
        .ptr     (ptr),
        .at_last (ptr_last)
    );

    cfb_blk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .load     (cnt_load && cnt_we),
        .load_val (cnt_wdata),
        .dec      (cnt_dec),
        .is_zero  (cnt_zero),
        .is_one   (cnt_one)
    );
endmodule

// File: rtl/cfb_chain_ctrl_chk.sv
module cfb_chain_ctrl_chk #(
    parameter int BLK_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             req_in,
    input logic             req_out,
    input logic             done,
    input logic             eng_start,
    input logic             eng_done,
    input logic [BLK_W-1:0] eng_result,
    input logic [BLK_W-1:0] eng_state_out,
    input logic [1:0]       phase
);
    localparam logic [1:0] PH_CIPHER = 2'd1;
    localparam logic [1:0] PH_DRAIN  = 2'd3;

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !eng_start); // R8
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_in && req_out)); // R5
    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (eng_state_out == '0 && !req_in && !req_out)); // R1
    AST_RESULT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CIPHER && eng_done && !soft_rst)
        |=> (eng_state_out == $past(eng_result) && req_in)); // R4
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_DRAIN || (phase == PH_CIPHER && !eng_done)) && !soft_rst)
        |=> $stable(eng_state_out)); // R9
endmodule

bind cfb_chain_ctrl cfb_chain_ctrl_chk #(.BLK_W(BLK_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .req_in        (req_in),
    .req_out       (req_out),
    .done          (done),
    .eng_start     (eng_start),
    .eng_done      (eng_done),
    .eng_result    (eng_result),
    .eng_state_out (eng_state_out),
    .phase         (phase)
);

// File: tb/cfb_chain_ctrl_tb.sv
`timescale 1ns/1ps
module cfb_chain_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         soft_rst = 1'b0;
    logic         wr_en = 1'b0;
    logic [15:0]  wr_data = '0;
    logic         rd_en = 1'b0;
    logic [15:0]  rd_data;
    logic         cnt_we = 1'b0;
    logic [15:0]  cnt_wdata = '0;
    logic         go = 1'b0;
    logic         req_in, req_out, done, eng_start;
    logic [127:0] eng_state_out;
    logic         eng_done = 1'b0;
    logic [127:0] eng_result = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cfb_chain_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .go(go),
        .req_in(req_in), .req_out(req_out), .done(done),
        .eng_start(eng_start), .eng_state_out(eng_state_out),
        .eng_done(eng_done), .eng_result(eng_result)
    );

    function automatic logic [127:0] cipher_f(input logic [127:0] x);
        return {x[126:0], x[127]} ^ 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    endfunction

    function automatic logic [15:0] pt_word(input int b, input int w);
        return 16'((b * 16'h1357) + (w * 16'h0f0f)) ^ 16'ha5a5;
    endfunction

    // stand-in engine: three-cycle latency
    logic [127:0] eng_cap = '0;
    int           eng_wait = 0;
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (!rst_n || soft_rst) begin
            eng_wait <= 0;
        end else if (eng_start) begin
            eng_cap  <= eng_state_out;
            eng_wait <= 3;
        end else if (eng_wait != 0) begin
            eng_wait <= eng_wait - 1;
            if (eng_wait == 1) begin
                eng_done   <= 1'b1;
                eng_result <= cipher_f(eng_cap);
            end
        end
    end

    // behavioural reference model, updated at every edge
    logic [127:0] m_st = '0;
    int m_ptr = 0, m_cnt = 0, m_ph = 0;
    bit m_start = 0, m_done = 0;
    always @(posedge clk) begin
        m_start = 0;
        m_done  = 0;
        if (!rst_n || soft_rst) begin
            m_st = '0; m_ptr = 0; m_cnt = 0; m_ph = 0;
        end else begin
            case (m_ph)
                0: begin
                    if (wr_en) begin
                        m_st[m_ptr*16 +: 16] = m_st[m_ptr*16 +: 16] ^ wr_data;
                        m_ptr = (m_ptr + 1) % 8;
                    end
                    if (go && m_cnt != 0) begin
                        m_ph = 1; m_start = 1; m_ptr = 0;
                    end
                    if (cnt_we) m_cnt = int'(cnt_wdata);
                end
                1: if (eng_done) begin
                    m_st = eng_result; m_ptr = 0; m_ph = 2;
                end
                2: if (wr_en) begin
                    m_st[m_ptr*16 +: 16] = m_st[m_ptr*16 +: 16] ^ wr_data;
                    if (m_ptr == 7) begin m_ptr = 0; m_ph = 3; end
                    else m_ptr = m_ptr + 1;
                end
                default: if (rd_en) begin
                    if (m_ptr == 7) begin
                        m_ptr = 0;
                        m_cnt = m_cnt - 1;
                        if (m_cnt == 0) begin m_ph = 0; m_done = 1; end
                        else begin m_ph = 1; m_start = 1; end
                    end else m_ptr = m_ptr + 1;
                end
            endcase
        end
    end

    task automatic check(input string req, input logic [127:0] act,
                         input logic [127:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check("R5", 128'(req_in), 128'(m_ph == 2), "req_in vs model");
            check("R6", 128'(req_out), 128'(m_ph == 3), "req_out vs model");
            check("R6", 128'(rd_data), 128'(m_st[m_ptr*16 +: 16]), "rd_data vs model");
            check("R3", 128'(eng_start), 128'(m_start), "eng_start vs model");
            check("R8", 128'(done), 128'(m_done), "done vs model");
            check("R2", eng_state_out, m_st, "register vs model");
        end
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_for(input bit want_in);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (want_in ? req_in : req_out) return;
        end
    endtask

    logic [127:0] iv = 128'h00112233_44556677_8899aabb_ccddeeff;
    logic [127:0] prev;
    logic [127:0] got;
    int starts = 0;
    always @(posedge clk) if (eng_start) starts++;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", eng_state_out, '0, "register after reset");
        check("R1", {126'd0, req_in, req_out}, '0, "requests after reset");

        // R2: IV load in IDLE
        for (int w = 0; w < 8; w++) begin
            wr_en = 1'b1; wr_data = iv[w*16 +: 16];
            @(negedge clk);
        end
        wr_en = 1'b0;
        @(negedge clk);
        check("R2", eng_state_out, iv, "IV placed by XOR writes");
        check("R2", 128'(starts), 128'd0, "no engine start from writes");

        // R3: start with zero count ignored
        go = 1'b1; @(negedge clk); go = 1'b0;
        repeat (4) @(negedge clk);
        check("R3", 128'(starts), 128'd0, "zero-count start ignored");

        // three-block run
        cnt_we = 1'b1; cnt_wdata = 16'd3; @(negedge clk); cnt_we = 1'b0;
        go = 1'b1; @(negedge clk); go = 1'b0;
        check("R3", 128'(eng_start), 128'd1, "start pulse after go");
        check("R3", eng_state_out, iv, "engine sees IV");
        prev = iv;
        for (int b = 0; b < 3; b++) begin
            // R9 / R10: stray write and count write while the engine runs
            wr_en = 1'b1; wr_data = 16'hdead; cnt_we = 1'b1; cnt_wdata = 16'd100;
            @(negedge clk);
            wr_en = 1'b0; cnt_we = 1'b0;
            check("R9", eng_state_out, prev, "write during CIPHER ignored");
            wait_for(1'b1);
            check("R4", eng_state_out, cipher_f(prev), "engine result loaded");
            // R9: stray read during FILL
            rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
            for (int w = 0; w < 8; w++) begin
                wr_en = 1'b1; wr_data = pt_word(b, w);
                @(negedge clk);
            end
            wr_en = 1'b0;
            check("R5", {126'd0, req_in, req_out}, 128'd1, "FILL ends into DRAIN");
            prev = cipher_f(prev);
            for (int w = 0; w < 8; w++) prev[w*16 +: 16] = prev[w*16 +: 16] ^ pt_word(b, w);
            got = '0;
            for (int w = 0; w < 8; w++) begin
                got[w*16 +: 16] = rd_data;
                rd_en = 1'b1;
                @(negedge clk);
            end
            rd_en = 1'b0;
            check("R6", got, prev, "ciphertext words read in order");
            if (b < 2) begin
                check("R7", 128'(eng_start), 128'd1, "next encryption launched by last read");
                check("R7", eng_state_out, prev, "engine input is ciphertext");
            end else begin
                check("R8", 128'(done), 128'd1, "done after last block");
                check("R8", 128'(eng_start), 128'd0, "no start after last block");
                check("R10", 128'(starts), 128'd3, "count write during run ignored");
            end
        end
        repeat (3) @(negedge clk);
        check("R8", 128'(starts), 128'd3, "controller idle after run");

        // R1: soft reset in the middle of a run
        cnt_we = 1'b1; cnt_wdata = 16'd2; @(negedge clk); cnt_we = 1'b0;
        go = 1'b1; @(negedge clk); go = 1'b0;
        wait_for(1'b1);
        for (int w = 0; w < 3; w++) begin
            wr_en = 1'b1; wr_data = 16'h1111; @(negedge clk);
        end
        wr_en = 1'b0;
        soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
        check("R1", eng_state_out, '0, "soft reset clears register");
        check("R1", {126'd0, req_in, req_out}, '0, "soft reset drops requests");
        repeat (6) @(negedge clk);
        check("R1", 128'(req_in), 128'd0, "stays idle after soft reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule